// File: doc/BRIEF.md
# ATA Device Task-File Register Bank and Command Decoder

This block is the device-side register bank behind a parallel ATA programmed-I/O port. The host's strobes arrive already synchronised as single-cycle read and write pulses. Each pulse carries two active-low bank selects (a command bank and a control bank) and a 3-bit register address. The block decodes each access into read-side and write-side registers, which differ at three addresses. It holds the feature, sector count, sector number, cylinder low/high and drive/head registers. A write to the command register starts command processing.

A written opcode is checked against a fixed list of supported commands. A supported opcode produces a one-cycle hand-off to a back end. The hand-off carries the opcode, feature, count and the 28-bit block address. The back end later returns a completion pulse with an error flag. An unsupported opcode is aborted locally. Either way the block updates its status and error registers and raises an interrupt request. The request is gated by the interrupt-disable bit and by drive selection. A software reset bit in the device control register holds the block busy and returns the task file to its defaults.

Top module: `ata_taskfile`

## Requirements
- R1: After reset, the registers read as follows: status 0x50, error 0x01, sector count 0x01, sector number 0x01, cylinder low/high 0x00, drive/head 0xA0. `irq` is low.
- R2: With `bank_cmd_n`=0 and `bank_ctl_n`=1, the decode is as follows. Addresses 2..6 write and read back count, sector, cylinder low, cylinder high and drive/head. Address 1 writes the feature register but reads the error register. Address 0 reads 0x00. Any access with both selects high, both low, or an unmapped control-bank address reads 0xFF and writes nothing. `rd_data` is valid the cycle after `rd_stb`.
- R3: With `bank_ctl_n`=0 and `bank_cmd_n`=1, address 6 reads alternate status and writes device control, where bit 1 disables interrupts and bit 2 is software reset. Address 7 reads a drive address byte with the following layout: bit 7 = 0, bit 6 = 1, bits 5:2 = inverted head nibble, bit 1 = inverted drive bit, bit 0 = drive bit.
- R4: A command write (command bank, address 7) to a selected, idle device sets BSY, so status reads 0xD0. The same write clears ERR and any pending interrupt.
- R5: A supported opcode produces exactly one `cmd_valid` pulse. It carries `cmd_op`, `cmd_feature` and `cmd_count`, plus `cmd_lba` = {drive/head[3:0], cylinder high, cylinder low, sector}, and `cmd_lba_mode` = drive/head bit 6. BSY is set while the pulse is high.
- R6: The supported list is 00,20,30,40,70,90,91,C4,C5,C6,C8,CA,E0..E6,E8,EC,EF. With `ENABLE_CFA`=1 (the default) it also includes 03,38,87,C0,CD.
- R7: Any other opcode produces no `cmd_valid`. BSY clears, status reads 0x51, the error register reads 0x04 (abort, bit 2), and an interrupt becomes pending.
- R8: A `done_stb` while a command is outstanding clears BSY and makes an interrupt pending. With `done_err`=0, status reads 0x50 and error reads 0x00. With `done_err`=1, status reads 0x51 and error reads 0x04.
- R9: `irq` is high only when an interrupt is pending, drive/head bit 4 equals `dev_id`, and the interrupt-disable bit is clear.
- R10: Reading status clears the pending interrupt. Reading alternate status leaves it pending.
- R11: A command write while drive/head bit 4 differs from `dev_id` is ignored: no BSY and no `cmd_valid`.
- R12: While BSY is set, writes to command-bank registers are ignored. Device control writes still take effect.
- R13: While software reset is set, status reads 0x80, the task file reads its reset values, no interrupt is pending, and writes other than device control are ignored. Clearing the bit returns status 0x50 and error 0x01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bank_cmd_n | input | 1 | Command register bank select, active low |
| bank_ctl_n | input | 1 | Control register bank select, active low |
| reg_addr | input | 3 | Register address within the bank |
| rd_stb | input | 1 | Single-cycle host read pulse |
| wr_stb | input | 1 | Single-cycle host write pulse |
| wr_data | input | 8 | Host write data |
| rd_data | output | 8 | Registered host read data |
| dev_id | input | 1 | This device's number from cable select |
| irq | output | 1 | Active-high interrupt request |
| cmd_valid | output | 1 | One-cycle command hand-off to the back end |
| cmd_op | output | 8 | Opcode of the handed-off command |
| cmd_feature | output | 8 | Feature register value |
| cmd_count | output | 8 | Sector count value |
| cmd_lba | output | 28 | Assembled block address |
| cmd_lba_mode | output | 1 | Address mode bit from drive/head |
| done_stb | input | 1 | Back-end completion pulse |
| done_err | input | 1 | Completion carries an error |

## Verification
The assertions watch a set of invariants on every cycle. A hand-off occurs only while busy and lasts exactly one cycle. The interrupt line is never high while busy. Software reset always holds the block busy and not ready. Busy writes leave the sector count untouched. A rejected opcode always ends in an abort error. The decoder never resolves a register unless exactly one bank is selected. Other properties need the bench's scenarios to show them, because they depend on the order of host accesses. These are the asymmetric read/write pairs, the fields carried by a hand-off, the difference between a status read and an alternate-status read, the gating by drive selection and by interrupt disable, and the restoration of defaults after software reset.

// File: rtl/ata_tf_pkg.sv
package ata_tf_pkg;
  localparam int TF_W   = 8;
  localparam int ADDR_W = 3;

  localparam int ST_BSY  = 7;
  localparam int ST_DRDY = 6;
  localparam int ST_DSC  = 4;
  localparam int ST_ERR  = 0;
  localparam int ER_ABRT = 2;
  localparam int DC_NIEN = 1;
  localparam int DC_SRST = 2;
  localparam int DH_DEV  = 4;
  localparam int DH_LBA  = 6;

  typedef enum logic [3:0] {
    TF_NONE, TF_DATA, TF_ERRFEAT, TF_COUNT, TF_SECT, TF_CYLLO,
    TF_CYLHI, TF_DEVHEAD, TF_STATCMD, TF_ALTCTL, TF_DRVADDR
  } tf_reg_e;

  typedef enum logic [1:0] {PH_IDLE, PH_CHECK, PH_WAIT} phase_e;
endpackage

// File: rtl/ata_tf_decode.sv
module ata_tf_decode
  import ata_tf_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              bank_cmd_n,
  input  logic              bank_ctl_n,
  input  logic [ADDR_W-1:0] reg_addr,
  output tf_reg_e           hit
);
  always_comb begin
    hit = TF_NONE;
    if (!bank_cmd_n && bank_ctl_n) begin
      case (reg_addr)
        3'd0: hit = TF_DATA;
        3'd1: hit = TF_ERRFEAT;
        3'd2: hit = TF_COUNT;
        3'd3: hit = TF_SECT;
        3'd4: hit = TF_CYLLO;
        3'd5: hit = TF_CYLHI;
        3'd6: hit = TF_DEVHEAD;
        default: hit = TF_STATCMD;
      endcase
    end else if (bank_cmd_n && !bank_ctl_n) begin
      if (reg_addr == 3'd6) hit = TF_ALTCTL;
      else if (reg_addr == 3'd7) hit = TF_DRVADDR;
    end
  end

  // R2
  one_bank_chk: assert property (@(posedge clk) disable iff (rst)
    (hit != TF_NONE) |-> (bank_cmd_n != bank_ctl_n));
endmodule

// File: rtl/ata_tf_opcheck.sv
module ata_tf_opcheck
  import ata_tf_pkg::*;
#(
  parameter bit ENABLE_CFA = 1'b1
) (
  input  logic [TF_W-1:0] op,
  output logic            supported
);
  localparam int N_BASE = 22;
  localparam int N_CFA  = 5;
  localparam logic [TF_W-1:0] BASE_OPS [N_BASE] = '{
    8'h00, 8'h20, 8'h30, 8'h40, 8'h70, 8'h90, 8'h91, 8'hC4, 8'hC5, 8'hC6, 8'hC8,
    8'hCA, 8'hE0, 8'hE1, 8'hE2, 8'hE3, 8'hE4, 8'hE5, 8'hE6, 8'hE8, 8'hEC, 8'hEF};
  localparam logic [TF_W-1:0] CFA_OPS [N_CFA] = '{8'h03, 8'h38, 8'h87, 8'hC0, 8'hCD};

  logic [N_BASE-1:0] base_hit;
  logic              cfa_any;

  for (genvar i = 0; i < N_BASE; i++) begin : g_base
    assign base_hit[i] = (op == BASE_OPS[i]);
  end

  if (ENABLE_CFA) begin : g_cfa
    logic [N_CFA-1:0] cfa_hit;
    for (genvar j = 0; j < N_CFA; j++) begin : g_ent
      assign cfa_hit[j] = (op == CFA_OPS[j]);
    end
    assign cfa_any = |cfa_hit;
  end else begin : g_nocfa
    assign cfa_any = 1'b0;
  end

  assign supported = (|base_hit) | cfa_any;
endmodule

// File: rtl/ata_taskfile.sv
module ata_taskfile
  import ata_tf_pkg::*;
#(
  parameter bit              ENABLE_CFA  = 1'b1,
  parameter logic [TF_W-1:0] DEF_DEVHEAD = 8'hA0,
  parameter logic [TF_W-1:0] DEF_DIAG    = 8'h01,
  localparam int             LBA_W       = 3*TF_W + 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bank_cmd_n,
  input  logic              bank_ctl_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              rd_stb,
  input  logic              wr_stb,
  input  logic [TF_W-1:0]   wr_data,
  output logic [TF_W-1:0]   rd_data,
  input  logic              dev_id,
  output logic              irq,
  output logic              cmd_valid,
  output logic [TF_W-1:0]   cmd_op,
  output logic [TF_W-1:0]   cmd_feature,
  output logic [TF_W-1:0]   cmd_count,
  output logic [LBA_W-1:0]  cmd_lba,
  output logic              cmd_lba_mode,
  input  logic              done_stb,
  input  logic              done_err
);
  tf_reg_e hit;
  logic    op_ok;

  logic [TF_W-1:0] feat_q, count_q, sect_q, cyllo_q, cylhi_q, devhead_q, err_q, op_q;
  logic [TF_W-1:0] rd_q;
  logic nien_q, srst_q, bsy_q, drdy_q, errbit_q, pend_q, valid_q;
  phase_e phase_q;

  ata_tf_decode i_dec (
    .clk(clk), .rst(rst), .bank_cmd_n(bank_cmd_n), .bank_ctl_n(bank_ctl_n),
    .reg_addr(reg_addr), .hit(hit)
  );

  ata_tf_opcheck #(.ENABLE_CFA(ENABLE_CFA)) i_opc (.op(op_q), .supported(op_ok));

  logic ctl_wr, srst_next, selected;
  logic [TF_W-1:0] status_w, drvaddr_w;

  assign ctl_wr    = wr_stb && (hit == TF_ALTCTL);
  assign srst_next = ctl_wr ? wr_data[DC_SRST] : srst_q;
  assign selected  = (devhead_q[DH_DEV] == dev_id);
  assign status_w  = {bsy_q, drdy_q, 1'b0, drdy_q, 3'b000, errbit_q};
  assign drvaddr_w = {1'b0, 1'b1, ~devhead_q[3:0], ~devhead_q[DH_DEV], devhead_q[DH_DEV]};

  always_ff @(posedge clk) begin
    if (rst) begin
      feat_q <= '0; count_q <= 8'h01; sect_q <= 8'h01; cyllo_q <= '0; cylhi_q <= '0;
      devhead_q <= DEF_DEVHEAD; err_q <= DEF_DIAG; op_q <= '0;
      nien_q <= 1'b0; srst_q <= 1'b0; bsy_q <= 1'b0; drdy_q <= 1'b1;
      errbit_q <= 1'b0; pend_q <= 1'b0; valid_q <= 1'b0; phase_q <= PH_IDLE;
    end else begin
      valid_q <= 1'b0;
      if (ctl_wr) begin
        nien_q <= wr_data[DC_NIEN];
        srst_q <= wr_data[DC_SRST];
      end
      if (srst_next) begin
        feat_q <= '0; count_q <= 8'h01; sect_q <= 8'h01; cyllo_q <= '0; cylhi_q <= '0;
        devhead_q <= DEF_DEVHEAD; err_q <= DEF_DIAG;
        bsy_q <= 1'b1; drdy_q <= 1'b0; errbit_q <= 1'b0; pend_q <= 1'b0;
        phase_q <= PH_IDLE;
      end else if (srst_q) begin
        bsy_q <= 1'b0; drdy_q <= 1'b1;
      end else begin
        if (rd_stb && hit == TF_STATCMD) pend_q <= 1'b0;
        if (wr_stb && !bsy_q) begin
          case (hit)
            TF_ERRFEAT: feat_q    <= wr_data;
            TF_COUNT:   count_q   <= wr_data;
            TF_SECT:    sect_q    <= wr_data;
            TF_CYLLO:   cyllo_q   <= wr_data;
            TF_CYLHI:   cylhi_q   <= wr_data;
            TF_DEVHEAD: devhead_q <= wr_data;
            TF_STATCMD: if (selected) begin
              op_q <= wr_data; bsy_q <= 1'b1; errbit_q <= 1'b0;
              pend_q <= 1'b0; phase_q <= PH_CHECK;
            end
            default: ;
          endcase
        end
        case (phase_q)
          PH_CHECK: begin
            if (op_ok) begin
              valid_q <= 1'b1;
              phase_q <= PH_WAIT;
            end else begin
              errbit_q <= 1'b1; err_q <= 8'(1 << ER_ABRT);
              bsy_q <= 1'b0; pend_q <= 1'b1; phase_q <= PH_IDLE;
            end
          end
          PH_WAIT: if (done_stb) begin
            errbit_q <= done_err;
            err_q    <= done_err ? 8'(1 << ER_ABRT) : 8'h00;
            bsy_q    <= 1'b0; pend_q <= 1'b1; phase_q <= PH_IDLE;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else if (rd_stb) begin
      case (hit)
        TF_DATA:    rd_q <= 8'h00;
        TF_ERRFEAT: rd_q <= err_q;
        TF_COUNT:   rd_q <= count_q;
        TF_SECT:    rd_q <= sect_q;
        TF_CYLLO:   rd_q <= cyllo_q;
        TF_CYLHI:   rd_q <= cylhi_q;
        TF_DEVHEAD: rd_q <= devhead_q;
        TF_STATCMD: rd_q <= status_w;
        TF_ALTCTL:  rd_q <= status_w;
        TF_DRVADDR: rd_q <= drvaddr_w;
        default:    rd_q <= 8'hFF;
      endcase
    end
  end

  assign rd_data      = rd_q;
  assign irq          = pend_q && selected && !nien_q;
  assign cmd_valid    = valid_q;
  assign cmd_op       = op_q;
  assign cmd_feature  = feat_q;
  assign cmd_count    = count_q;
  assign cmd_lba      = {devhead_q[3:0], cylhi_q, cyllo_q, sect_q};
  assign cmd_lba_mode = devhead_q[DH_LBA];

  // R5
  valid_busy_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> bsy_q);
  // R5
  valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |=> !cmd_valid);
  // R9
  irq_idle_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> !bsy_q);
  // R13
  srst_busy_chk: assert property (@(posedge clk) disable iff (rst)
    srst_q |-> (bsy_q && !drdy_q && !irq));
  // R12
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (bsy_q && !srst_q && !ctl_wr && wr_stb && hit == TF_COUNT) |=> $stable(count_q));
  // R7
  abort_chk: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_CHECK && !op_ok && !srst_next && !srst_q)
      |=> (errbit_q && err_q == 8'h04 && !bsy_q && !cmd_valid));
endmodule

// File: tb/test_ata_taskfile.sv
module test_ata_taskfile;
  logic clk = 1'b0, rst = 1'b1;
  logic bank_cmd_n = 1'b1, bank_ctl_n = 1'b1;
  logic [2:0] reg_addr = '0;
  logic rd_stb = 1'b0, wr_stb = 1'b0, dev_id = 1'b0;
  logic [7:0] wr_data = '0, rd_data;
  logic irq, cmd_valid, cmd_lba_mode, done_stb = 1'b0, done_err = 1'b0;
  logic [7:0] cmd_op, cmd_feature, cmd_count;
  logic [27:0] cmd_lba;

  int tests = 0, fails = 0, vcount = 0;
  bit finished = 1'b0;
  logic [7:0] c_op, c_feat, c_cnt;
  logic [27:0] c_lba;
  logic c_mode;
  logic [7:0] v;

  always #5 clk = ~clk;

  ata_taskfile i_ata_taskfile (
    .clk(clk), .rst(rst), .bank_cmd_n(bank_cmd_n), .bank_ctl_n(bank_ctl_n),
    .reg_addr(reg_addr), .rd_stb(rd_stb), .wr_stb(wr_stb), .wr_data(wr_data),
    .rd_data(rd_data), .dev_id(dev_id), .irq(irq), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .cmd_feature(cmd_feature), .cmd_count(cmd_count),
    .cmd_lba(cmd_lba), .cmd_lba_mode(cmd_lba_mode),
    .done_stb(done_stb), .done_err(done_err)
  );

  always @(negedge clk) if (cmd_valid) begin
    vcount++; c_op = cmd_op; c_feat = cmd_feature; c_cnt = cmd_count;
    c_lba = cmd_lba; c_mode = cmd_lba_mode;
  end

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic cn, input logic tn, input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bank_cmd_n = cn; bank_ctl_n = tn; reg_addr = a; wr_data = d; wr_stb = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0; bank_cmd_n = 1'b1; bank_ctl_n = 1'b1;
  endtask

  task automatic rd(input logic cn, input logic tn, input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    bank_cmd_n = cn; bank_ctl_n = tn; reg_addr = a; rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0; bank_cmd_n = 1'b1; bank_ctl_n = 1'b1;
    d = rd_data;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_cmd(input logic e);
    @(negedge clk); done_stb = 1'b1; done_err = e;
    @(negedge clk); done_stb = 1'b0; done_err = 1'b0;
    idle(2);
  endtask

  task automatic t_reset();
    rd(0,1,7,v); check("R1 status", v, 8'h50);
    rd(0,1,1,v); check("R1 error", v, 8'h01);
    rd(0,1,2,v); check("R1 count", v, 8'h01);
    rd(0,1,3,v); check("R1 sector", v, 8'h01);
    rd(0,1,4,v); check("R1 cyl lo", v, 8'h00);
    rd(0,1,5,v); check("R1 cyl hi", v, 8'h00);
    rd(0,1,6,v); check("R1 devhead", v, 8'hA0);
    check("R1 irq", irq, 1'b0);
    rd(1,0,7,v); check("R3 drive address", v, 8'h7E);
  endtask

  task automatic t_decode();
    wr(0,1,1,8'h5A); rd(0,1,1,v); check("R2 feature write reads error", v, 8'h01);
    rd(0,1,0,v); check("R2 data port", v, 8'h00);
    wr(1,1,2,8'h99); rd(1,1,2,v); check("R2 no bank reads FF", v, 8'hFF);
    rd(0,1,2,v); check("R2 no-bank write ignored", v, 8'h01);
    rd(0,0,2,v); check("R2 both banks reads FF", v, 8'hFF);
    rd(1,0,0,v); check("R2 unmapped control address", v, 8'hFF);
    rd(1,0,6,v); check("R3 alt status", v, 8'h50);
  endtask

  task automatic t_good_cmd();
    int base;
    wr(0,1,2,8'h08); wr(0,1,3,8'h11); wr(0,1,4,8'h22); wr(0,1,5,8'h33); wr(0,1,6,8'hE5);
    rd(0,1,6,v); check("R2 devhead readback", v, 8'hE5);
    rd(1,0,7,v); check("R3 drive address head 5", v, 8'h6A);
    base = vcount;
    wr(0,1,7,8'h20);
    rd(0,1,7,v); check("R4 busy status", v, 8'hD0);
    idle(2);
    check("R5 one pulse", vcount - base, 1);
    check("R5 op", c_op, 8'h20);
    check("R5 feature", c_feat, 8'h5A);
    check("R5 count", c_cnt, 8'h08);
    check("R5 lba", c_lba, 28'h5332211);
    check("R5 lba mode", c_mode, 1'b1);
    finish_cmd(1'b0);
    check("R8 irq raised", irq, 1'b1);
    rd(1,0,6,v); check("R8 alt status done", v, 8'h50);
    check("R10 alt status keeps irq", irq, 1'b1);
    rd(0,1,1,v); check("R8 error clean", v, 8'h00);
    rd(0,1,7,v); check("R10 status", v, 8'h50);
    idle(1); check("R10 status read clears irq", irq, 1'b0);
  endtask

  task automatic t_abort();
    int base = vcount;
    wr(0,1,7,8'hE7); idle(3);
    check("R7 no hand-off", vcount - base, 0);
    check("R7 irq", irq, 1'b1);
    rd(0,1,1,v); check("R7 abort error", v, 8'h04);
    rd(0,1,7,v); check("R7 status", v, 8'h51);
    base = vcount;
    wr(0,1,7,8'h10); idle(3);
    check("R6 unlisted 10 rejected", vcount - base, 0);
    rd(0,1,7,v);
  endtask

  task automatic t_done_err();
    wr(0,1,7,8'hC8); idle(3);
    rd(0,1,7,v); check("R4 cmd clears ERR", v, 8'hD0);
    finish_cmd(1'b1);
    rd(0,1,7,v); check("R8 err status", v, 8'h51);
    rd(0,1,1,v); check("R8 err code", v, 8'h04);
  endtask

  task automatic t_cfa();
    int base = vcount;
    wr(0,1,7,8'hC0); idle(3);
    check("R6 CFA accepted", vcount - base, 1);
    check("R6 CFA op", c_op, 8'hC0);
    finish_cmd(1'b0); rd(0,1,7,v);
  endtask

  task automatic t_busy_nien();
    wr(0,1,7,8'hEC); idle(3);
    wr(0,1,2,8'h77);
    wr(1,0,6,8'h02);
    finish_cmd(1'b0);
    rd(0,1,2,v); check("R12 busy write ignored", v, 8'h08);
    check("R9 nIEN masks irq", irq, 1'b0);
    wr(1,0,6,8'h00); idle(1);
    check("R9 unmask irq", irq, 1'b1);
    wr(0,1,6,8'hF0); idle(1);
    check("R9 other drive masks irq", irq, 1'b0);
    wr(0,1,6,8'hA0); idle(1);
    check("R9 reselect irq", irq, 1'b1);
    rd(0,1,7,v);
  endtask

  task automatic t_devsel();
    int base;
    wr(0,1,6,8'hB0);
    base = vcount;
    wr(0,1,7,8'h20); idle(3);
    check("R11 unselected command no hand-off", vcount - base, 0);
    rd(0,1,7,v); check("R11 unselected not busy", v, 8'h50);
    dev_id = 1'b1;
    wr(0,1,7,8'h00); idle(3);
    check("R11 device 1 selected accepts", vcount - base, 1);
    finish_cmd(1'b0);
    check("R9 device 1 irq", irq, 1'b1);
    rd(0,1,7,v); dev_id = 1'b0; wr(0,1,6,8'hA0);
  endtask

  task automatic t_srst();
    wr(0,1,2,8'h44);
    wr(1,0,6,8'h04);
    rd(0,1,7,v); check("R13 srst status", v, 8'h80);
    rd(0,1,2,v); check("R13 count default", v, 8'h01);
    wr(0,1,3,8'h55);
    rd(0,1,3,v); check("R13 write ignored in srst", v, 8'h01);
    wr(1,0,6,8'h00);
    rd(0,1,7,v); check("R13 release status", v, 8'h50);
    rd(0,1,1,v); check("R13 release error", v, 8'h01);
    rd(0,1,6,v); check("R13 devhead default", v, 8'hA0);
    check("R13 no irq", irq, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    idle(3); rst = 1'b0; idle(1);
    t_reset();
    t_decode();
    t_good_cmd();
    t_abort();
    t_done_err();
    t_cfa();
    t_busy_nien();
    t_devsel();
    t_srst();
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule